// File: doc/BRIEF.md
# Serial EEPROM Pin Ownership Arbiter

This block sits between the four SPI pins of a serial EEPROM and an internal hardware engine that normally reads and writes that EEPROM. It exposes one control/status register through which host software can ask to take the pins over. Once ownership is granted, software drives serial clock, chip select and data toward the memory by writing register bits, and reads back the memory's data output from a status bit. This lets software run arbitrary SPI command sequences, one bit per register write.

Ownership uses a request/grant handshake. Software sets a request bit, and the block raises a hold signal toward the engine. The block grants the pins only once the engine reports that it is idle, so a transfer already in progress finishes first. Clearing the request hands the pins back with chip select deasserted. If software stops toggling the pins for a configurable number of cycles, an inactivity timer withdraws the request on its own. The register also shows two strap inputs: whether an EEPROM is fitted, and its size code.

Top module: `eeprom_pin_owner`

## Requirements
- R1: After reset the register reads serial clock 0 (bit 0), chip select 1 (bit 1, active low), data out 0 (bit 2), request 0 (bit 6) and grant 0 (bit 7).
- R2: Bit 8 reads the `ee_present` input and bits 14:11 read `ee_size_code` unchanged (7 means 16 KB, 8 means 32 KB). Bits 5:4, 10:9 and 31:15 read zero. Writing ones to read-only bits has no effect on the value read back.
- R3: Bit 3 reads the `pin_miso` level as it was SYNC_STAGES clock edges earlier.
- R4: A write updates bits 0, 1, 2 and 6 on the next clock edge, and `eng_hold` equals the request bit.
- R5: Grant rises one edge after a cycle in which the request is set and `eng_busy` is low. While `eng_busy` stays high, grant stays low.
- R6: While grant is high, `pin_sck`, `pin_cs_n` and `pin_mosi` equal register bits 0, 1 and 2.
- R7: While grant is low, the pins follow `eng_sck`, `eng_cs_n` and `eng_mosi`, and register bits 0 to 2 have no effect on them.
- R8: One edge after a cycle in which grant is high and the request is low, grant is low and bit 1 reads 1.
- R9: When grant is held through IDLE_CYCLES edges after the last change of bits 0 to 2, the request clears on the IDLE_CYCLES-th edge and grant falls one edge later.
- R10: A write that changes any of bits 0 to 2 restarts the inactivity count. A write that leaves them unchanged does not restart it, even if it sets the request again.
- R11: `eng_miso` always equals `pin_miso`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | REG_W | Register write value |
| reg_rd_data | output | REG_W | Register read value |
| eng_busy | input | 1 | Internal engine has a transfer in progress |
| eng_hold | output | 1 | Asks the engine to finish and start nothing new |
| eng_sck | input | 1 | Engine serial clock |
| eng_cs_n | input | 1 | Engine chip select, active low |
| eng_mosi | input | 1 | Engine data toward the EEPROM |
| eng_miso | output | 1 | EEPROM data returned to the engine |
| ee_present | input | 1 | Strap: an EEPROM is fitted |
| ee_size_code | input | SIZE_W | Strap: EEPROM size code |
| pin_sck | output | 1 | Serial clock pin |
| pin_cs_n | output | 1 | Chip select pin, active low |
| pin_mosi | output | 1 | Data pin toward the EEPROM |
| pin_miso | input | 1 | Data pin from the EEPROM |

## Verification
The bound checker checks several rules on every cycle: the pins come from the register whenever grant is high and from the engine otherwise, grant never rises without a prior request or while the engine is busy, a dropped request removes grant on the next edge with chip select released, and grant never outlives IDLE_CYCLES edges without pin activity. The bench scenarios cover what a per-cycle rule cannot show. These are the exact edge on which the timeout fires, the difference between a write that restarts the count and one that does not, the delay of the data-in sampling, and the read-only fields.

// File: rtl/eeprom_pin_pkg.sv
package eeprom_pin_pkg;

    // Register bit positions; software decodes these, so they are fixed.
    localparam int unsigned BIT_SCK     = 0;
    localparam int unsigned BIT_CS      = 1;
    localparam int unsigned BIT_MOSI    = 2;
    localparam int unsigned BIT_MISO    = 3;
    localparam int unsigned BIT_REQ     = 6;
    localparam int unsigned BIT_GNT     = 7;
    localparam int unsigned BIT_PRES    = 8;
    localparam int unsigned BIT_SIZE_LO = 11;

    typedef struct packed {
        logic sck;
        logic cs_n;
        logic mosi;
    } pin_drive_t;

    typedef struct packed {
        pin_drive_t drv;
        logic       req;
        logic       grant;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{
        drv:   '{sck: 1'b0, cs_n: 1'b1, mosi: 1'b0},
        req:   1'b0,
        grant: 1'b0
    };

endpackage

// File: rtl/eeprom_pin_idle_timer.sv
module eeprom_pin_idle_timer #(
    parameter int unsigned IDLE_CYCLES = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    localparam int unsigned CNT_W = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && !restart && (cnt_q == LAST);
        if (!run || restart || expire) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/eeprom_pin_sampler.sv
module eeprom_pin_sampler #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES:0] tap;

    assign tap[0] = din;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic stage_d, stage_q;
        assign stage_d = tap[g];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= 1'b0;
            end else begin
                stage_q <= stage_d;
            end
        end
        assign tap[g+1] = stage_q;
    end

    assign dout = tap[STAGES];
endmodule

// File: rtl/eeprom_pin_mux.sv
module eeprom_pin_mux
    import eeprom_pin_pkg::*;
(
    input  logic       own,
    input  pin_drive_t sw_drv,
    input  pin_drive_t hw_drv,
    output pin_drive_t pin_drv
);
    always_comb begin
        pin_drv = own ? sw_drv : hw_drv;
    end
endmodule

// File: rtl/eeprom_pin_owner.sv
module eeprom_pin_owner
    import eeprom_pin_pkg::*;
#(
    parameter int unsigned REG_W       = 32,
    parameter int unsigned SIZE_W      = 4,
    parameter int unsigned IDLE_CYCLES = 250_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wr_data,
    output logic [REG_W-1:0]  reg_rd_data,
    input  logic              eng_busy,
    output logic              eng_hold,
    input  logic              eng_sck,
    input  logic              eng_cs_n,
    input  logic              eng_mosi,
    output logic              eng_miso,
    input  logic              ee_present,
    input  logic [SIZE_W-1:0] ee_size_code,
    output logic              pin_sck,
    output logic              pin_cs_n,
    output logic              pin_mosi,
    input  logic              pin_miso
);
    localparam int unsigned SIZE_HI = BIT_SIZE_LO + SIZE_W - 1;

    ctrl_state_t st_d, st_q;
    pin_drive_t  wr_drv, eng_drv, out_drv;
    logic        activity, expire, miso_s;
    logic        unused_wr_bits;

    assign unused_wr_bits = ^reg_wr_data;

    // Next-state logic
    always_comb begin
        wr_drv.sck  = reg_wr_data[BIT_SCK];
        wr_drv.cs_n = reg_wr_data[BIT_CS];
        wr_drv.mosi = reg_wr_data[BIT_MOSI];
        activity    = reg_wr_en && (wr_drv != st_q.drv);

        st_d = st_q;
        if (reg_wr_en) begin
            st_d.drv = wr_drv;
            st_d.req = reg_wr_data[BIT_REQ];
        end
        // Inactivity expiry overrides a same-cycle request rewrite.
        if (expire) begin
            st_d.req = 1'b0;
        end
        // Grant only from an idle engine; once held it stays while requested.
        st_d.grant = st_q.req && (st_q.grant || !eng_busy);
        // Handing back: leave the select field deasserted.
        if (st_q.grant && !st_q.req) begin
            st_d.drv.cs_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    eeprom_pin_idle_timer #(
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.grant),
        .restart (activity),
        .expire  (expire)
    );

    eeprom_pin_sampler #(
        .STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_miso),
        .dout  (miso_s)
    );

    always_comb begin
        eng_drv.sck  = eng_sck;
        eng_drv.cs_n = eng_cs_n;
        eng_drv.mosi = eng_mosi;
    end

    eeprom_pin_mux u_mux (
        .own     (st_q.grant),
        .sw_drv  (st_q.drv),
        .hw_drv  (eng_drv),
        .pin_drv (out_drv)
    );

    assign pin_sck  = out_drv.sck;
    assign pin_cs_n = out_drv.cs_n;
    assign pin_mosi = out_drv.mosi;
    assign eng_hold = st_q.req;
    assign eng_miso = pin_miso;

    // Read view
    always_comb begin
        reg_rd_data                       = '0;
        reg_rd_data[BIT_SCK]              = st_q.drv.sck;
        reg_rd_data[BIT_CS]               = st_q.drv.cs_n;
        reg_rd_data[BIT_MOSI]             = st_q.drv.mosi;
        reg_rd_data[BIT_MISO]             = miso_s;
        reg_rd_data[BIT_REQ]              = st_q.req;
        reg_rd_data[BIT_GNT]              = st_q.grant;
        reg_rd_data[BIT_PRES]             = ee_present;
        reg_rd_data[SIZE_HI:BIT_SIZE_LO]  = ee_size_code;
    end
endmodule

// File: rtl/eeprom_pin_owner_chk.sv
module eeprom_pin_owner_chk #(
    parameter int unsigned IDLE_CYCLES = 250_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_pins,
    input logic [2:0] rd_pins,
    input logic       rd_req,
    input logic       rd_grant,
    input logic       eng_busy,
    input logic       eng_sck,
    input logic       eng_cs_n,
    input logic       eng_mosi,
    input logic       pin_sck,
    input logic       pin_cs_n,
    input logic       pin_mosi
);
    int unsigned idle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 0;
        end else if (!rd_grant || (wr_en && (wr_pins != rd_pins))) begin
            idle_q <= 0;
        end else begin
            idle_q <= idle_q + 1;
        end
    end

    p_grant_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> $past(rd_req));

    p_grant_engine_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_grant) |-> $past(!eng_busy));

    p_pins_from_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> ({pin_mosi, pin_cs_n, pin_sck} == rd_pins));

    p_pins_from_engine_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_grant |-> ({pin_mosi, pin_cs_n, pin_sck} == {eng_mosi, eng_cs_n, eng_sck}));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant && !rd_req) |=> (!rd_grant && rd_pins[1]));

    p_idle_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> (idle_q <= IDLE_CYCLES));
endmodule

bind eeprom_pin_owner eeprom_pin_owner_chk #(
    .IDLE_CYCLES (IDLE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_pins  (reg_wr_data[2:0]),
    .rd_pins  (reg_rd_data[2:0]),
    .rd_req   (reg_rd_data[eeprom_pin_pkg::BIT_REQ]),
    .rd_grant (reg_rd_data[eeprom_pin_pkg::BIT_GNT]),
    .eng_busy (eng_busy),
    .eng_sck  (eng_sck),
    .eng_cs_n (eng_cs_n),
    .eng_mosi (eng_mosi),
    .pin_sck  (pin_sck),
    .pin_cs_n (pin_cs_n),
    .pin_mosi (pin_mosi)
);

// File: tb/sim_eeprom_pin_owner.sv
module sim_eeprom_pin_owner;
    localparam int CLK_PERIOD = 10;
    localparam int IDLE       = 40;
    localparam int SYNC       = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        eng_busy = 1'b0;
    logic        eng_hold;
    logic        eng_sck = 1'b0;
    logic        eng_cs_n = 1'b1;
    logic        eng_mosi = 1'b0;
    logic        eng_miso;
    logic        ee_present = 1'b1;
    logic [3:0]  ee_size_code = 4'd7;
    logic        pin_sck, pin_cs_n, pin_mosi;
    logic        pin_miso = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_pin_owner #(
        .REG_W       (32),
        .SIZE_W      (4),
        .IDLE_CYCLES (IDLE),
        .SYNC_STAGES (SYNC)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_data  (reg_wr_data),
        .reg_rd_data  (reg_rd_data),
        .eng_busy     (eng_busy),
        .eng_hold     (eng_hold),
        .eng_sck      (eng_sck),
        .eng_cs_n     (eng_cs_n),
        .eng_mosi     (eng_mosi),
        .eng_miso     (eng_miso),
        .ee_present   (ee_present),
        .ee_size_code (ee_size_code),
        .pin_sck      (pin_sck),
        .pin_cs_n     (pin_cs_n),
        .pin_mosi     (pin_mosi),
        .pin_miso     (pin_miso)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic set_eng(input logic s, input logic c, input logic m);
        eng_sck = s; eng_cs_n = c; eng_mosi = m;
    endtask

    task automatic t_reset;
        check("R1 sck", 32'(reg_rd_data[0]), 32'd0);
        check("R1 cs", 32'(reg_rd_data[1]), 32'd1);
        check("R1 mosi", 32'(reg_rd_data[2]), 32'd0);
        check("R1 req", 32'(reg_rd_data[6]), 32'd0);
        check("R1 grant", 32'(reg_rd_data[7]), 32'd0);
    endtask

    task automatic t_status;
        check("R2 present/size", reg_rd_data & 32'hFFFF_FF30, 32'h0000_3900);
        ee_present = 1'b0; ee_size_code = 4'd8;
        wr(32'hFFFF_FFB8);
        check("R2 ro ignored", reg_rd_data, 32'h0000_4000);
        ee_present = 1'b1;
        wr(32'h0000_0002);
    endtask

    task automatic t_engine;
        set_eng(1'b1, 1'b0, 1'b1);
        wr(32'h0000_0002);
        tick(1);
        check("R7 pins follow engine", {29'd0, pin_mosi, pin_cs_n, pin_sck}, 32'd5);
        set_eng(1'b0, 1'b1, 1'b0);
        wr(32'h0000_0005);
        check("R7 reg bits ignored", {29'd0, pin_mosi, pin_cs_n, pin_sck}, 32'd2);
        pin_miso = 1'b1;
        #1;
        check("R11 miso to engine", 32'(eng_miso), 32'd1);
        pin_miso = 1'b0;
        wr(32'h0000_0002);
    endtask

    task automatic t_miso;
        tick(SYNC + 1);
        pin_miso = 1'b1;
        tick(SYNC - 1);
        check("R3 miso not yet", 32'(reg_rd_data[3]), 32'd0);
        tick(1);
        check("R3 miso sampled", 32'(reg_rd_data[3]), 32'd1);
        pin_miso = 1'b0;
        tick(SYNC);
    endtask

    task automatic t_handshake;
        eng_busy = 1'b1;
        wr(32'h0000_0042);
        check("R4 req set", 32'(reg_rd_data[6]), 32'd1);
        check("R4 hold", 32'(eng_hold), 32'd1);
        tick(3);
        check("R5 grant waits for busy", 32'(reg_rd_data[7]), 32'd0);
        eng_busy = 1'b0;
        tick(1);
        check("R5 grant after idle", 32'(reg_rd_data[7]), 32'd1);
    endtask

    task automatic t_reg_pins;
        set_eng(1'b0, 1'b1, 1'b0);
        wr(32'h0000_0045);
        check("R6 pins from reg a", {29'd0, pin_mosi, pin_cs_n, pin_sck}, 32'd5);
        set_eng(1'b1, 1'b0, 1'b1);
        wr(32'h0000_0042);
        check("R6 pins from reg b", {29'd0, pin_mosi, pin_cs_n, pin_sck}, 32'd2);
    endtask

    task automatic t_release;
        wr(32'h0000_0040);
        check("R6 select low", 32'(pin_cs_n), 32'd0);
        wr(32'h0000_0000);
        check("R8 req cleared", 32'(reg_rd_data[7:6]), 32'd2);
        tick(1);
        check("R8 grant gone", 32'(reg_rd_data[7]), 32'd0);
        check("R8 select released", 32'(reg_rd_data[1]), 32'd1);
        check("R8 pins back to engine", {29'd0, pin_mosi, pin_cs_n, pin_sck}, 32'd5);
        set_eng(1'b0, 1'b1, 1'b0);
    endtask

    task automatic take_pins;
        wr(32'h0000_0042);
        tick(1);
    endtask

    task automatic t_timeout;
        take_pins();
        check("R9 granted", 32'(reg_rd_data[7]), 32'd1);
        wr(32'h0000_0043);
        tick(IDLE - 1);
        check("R9 req before expiry", 32'(reg_rd_data[6]), 32'd1);
        tick(1);
        check("R9 req at expiry", 32'(reg_rd_data[7:6]), 32'd2);
        tick(1);
        check("R9 grant dropped", 32'(reg_rd_data[7]), 32'd0);
    endtask

    task automatic t_restart;
        take_pins();
        wr(32'h0000_0043);
        tick(19);
        wr(32'h0000_0043);
        tick(IDLE - 21);
        check("R10 same write no restart, before", 32'(reg_rd_data[6]), 32'd1);
        tick(1);
        check("R10 same write no restart, expiry", 32'(reg_rd_data[6]), 32'd0);
        tick(2);
        take_pins();
        wr(32'h0000_0043);
        tick(19);
        wr(32'h0000_0041);
        tick(IDLE - 1);
        check("R10 change restarts, before", 32'(reg_rd_data[6]), 32'd1);
        tick(1);
        check("R10 change restarts, expiry", 32'(reg_rd_data[6]), 32'd0);
        tick(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_status();
        t_engine();
        t_miso();
        t_handshake();
        t_reg_pins();
        t_release();
        t_timeout();
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule